// File: doc/BRIEF.md
# Periodic Interrupt Flag Generator

This block generates two periodic interrupt sources: a display-refresh tick with a period of about 16.63 ms (roughly 60.15 Hz) and a one-second tick. Both feed a pair of registers in the style of a classic 6522 adapter: an interrupt flag register and an interrupt enable register. A host reads and writes these registers over a byte-wide port. The register offset is taken from address bits 12:9, so neighbouring registers are 0x200 bytes apart. Each period is a clock-cycle count set by a parameter.

Each tick falls on a whole multiple of its period, counted from the release of reset. Register traffic never moves that phase. A tick always sets its flag, whether or not the matching enable bit is set. A set flag stays set until the host clears it. The interrupt output goes high when any flag is set and its enable is also set.

Top module: `periodic_irq_flags`

## Requirements
- R1: Flag bit 1 (refresh tick) becomes set after clock edge number k·VBL_CYCLES following reset release, for every k ≥ 1, and not one edge earlier. Register reads and writes do not move this phase.
- R2: Flag bit 0 (one-second tick) becomes set after clock edge number k·SEC_CYCLES following reset release, for every k ≥ 1, and not one edge earlier.
- R3: A tick sets its flag even when the matching enable bit is clear. The flag then stays set until it is cleared.
- R4: A write to the flag register (offset 13) clears every flag whose data bit (6:0) is 1. Data bit 7 and data bits that are 0 have no effect. Flag bits 6:2 always read 0.
- R5: When a tick and a clearing write reach the same flag on the same edge, the flag ends up set.
- R6: A write to the enable register (offset 14) with data bit 7 = 1 sets the enable bits given by data bits 6:0. With data bit 7 = 0 it clears them. All other enable bits keep their value. A read of the enable register returns bit 7 as 1 and the enables in bits 6:0.
- R7: `irq` is high exactly when some flag bit and its enable bit are both 1. Bit 7 of a flag register read equals `irq`.
- R8: Only address bits 12:9 select the register. Reads of any offset other than 13 or 14 return 0, and writes to those offsets change nothing.
- R9: Synchronous reset clears all flags and enables, drives `irq` low, and restarts both period phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe |
| wr_en | input | 1 | 1 = write, 0 = read (when `sel` is high) |
| addr | input | 13 | Byte address; bits 12:9 give the register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational, 0 when not reading) |
| irq | output | 1 | Interrupt request |

## Verification
Ticks are exercised in four settings, each of which exposes a different class of fault:
- Left alone from reset, with readings just before and just on the first boundary. This exposes an off-by-one period.
- Interleaved with enable and flag writes. This shows whether register traffic disturbs the phase or whether enables gate the latching.
- Cleared on the exact edge where a tick lands. This separates set-priority from clear-priority.
- Accessed through aliased addresses and through undecoded offsets. This shows whether decoding uses anything beyond bits 12:9.

A cycle-level model in the bench, built from the requirements, supplies the expected values for the table-driven sequence.

// File: rtl/pif_pkg.sv
package pif_pkg;

    localparam int ADDR_W   = 13;
    localparam int OFS_LSB  = 9;
    localparam int OFS_W    = 4;
    localparam int FLAG_W   = 7;

    localparam logic [OFS_W-1:0] OFS_FLAG   = 4'd13;
    localparam logic [OFS_W-1:0] OFS_ENABLE = 4'd14;

    localparam int NUM_SRC  = 2;
    localparam int SRC_SEC  = 0;
    localparam int SRC_VBL  = 1;

    typedef struct packed {
        logic              wr_flag;
        logic              wr_enable;
        logic              set_mode;
        logic [FLAG_W-1:0] mask;
    } reg_wr_t;

    function automatic logic [OFS_W-1:0] reg_offset(input logic [ADDR_W-1:0] a);
        return a[OFS_LSB +: OFS_W];
    endfunction

    function automatic logic [7:0] flag_readback(input logic [FLAG_W-1:0] f,
                                                 input logic [FLAG_W-1:0] e);
        return {|(f & e), f};
    endfunction

endpackage

// File: rtl/pif_period_tick.sv
module pif_period_tick #(
    parameter int unsigned PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R1: phase counter never leaves its range
    a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    generate
        if (PERIOD > 1) begin : g_gap
            // R1: two ticks are never adjacent when the period exceeds one cycle
            a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pif_flag_bank.sv
module pif_flag_bank
    import pif_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   events,
    input  reg_wr_t           wr,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] enables,
    output logic              irq
);
    logic [FLAG_W-1:0] ev_ext;
    logic [FLAG_W-1:0] clr_mask;

    assign ev_ext   = {{(FLAG_W-NSRC){1'b0}}, events};
    assign clr_mask = wr.wr_flag ? wr.mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | ev_ext;
            if (wr.wr_enable) begin
                if (wr.set_mode) enables <= enables | wr.mask;
                else             enables <= enables & ~wr.mask;
            end
        end
    end

    assign irq = |(flags & enables);

    // R3: a flag stays set unless a clearing write names it
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flags & ~clr_mask) & ~flags) == '0));

    // R5: an event always leaves its flag set, clearing write or not
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_ext != '0) |=> ((flags & $past(ev_ext)) == $past(ev_ext)));

    // R4: flag bits without a source stay clear
    a_r4_unused_zero: assert property (@(posedge clk) disable iff (rst)
        flags[FLAG_W-1:NSRC] == '0);

    // R6: enables hold when no enable write occurs
    a_r6_enable_hold: assert property (@(posedge clk) disable iff (rst)
        !wr.wr_enable |=> $stable(enables));

endmodule

// File: rtl/periodic_irq_flags.sv
module periodic_irq_flags
    import pif_pkg::*;
#(
    parameter int unsigned VBL_CYCLES = 2078750,
    parameter int unsigned SEC_CYCLES = 125000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq
);
    logic [NUM_SRC-1:0] events;
    logic [FLAG_W-1:0]  flags;
    logic [FLAG_W-1:0]  enables;
    logic [OFS_W-1:0]   ofs;
    reg_wr_t            wr;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            localparam int unsigned P = (g == SRC_VBL) ? VBL_CYCLES : SEC_CYCLES;
            pif_period_tick #(.PERIOD(P)) u_tick (
                .clk  (clk),
                .rst  (rst),
                .tick (events[g])
            );
        end
    endgenerate

    assign ofs          = reg_offset(addr);
    assign wr.wr_flag   = sel && wr_en && (ofs == OFS_FLAG);
    assign wr.wr_enable = sel && wr_en && (ofs == OFS_ENABLE);
    assign wr.set_mode  = wdata[7];
    assign wr.mask      = wdata[FLAG_W-1:0];

    pif_flag_bank #(.NSRC(NUM_SRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .events  (events),
        .wr      (wr),
        .flags   (flags),
        .enables (enables),
        .irq     (irq)
    );

    always_comb begin
        rdata = '0;
        if (sel && !wr_en) begin
            case (ofs)
                OFS_FLAG:   rdata = flag_readback(flags, enables);
                OFS_ENABLE: rdata = {1'b1, enables};
                default:    rdata = '0;
            endcase
        end
    end

    // R7: summary bit of a flag read matches the interrupt pin
    a_r7_summary_matches_irq: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && ofs == OFS_FLAG) |-> (rdata[7] == irq));

    // R8: undecoded offsets read as zero
    a_r8_other_offset_zero: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && ofs != OFS_FLAG && ofs != OFS_ENABLE) |-> (rdata == 8'h00));

endmodule

// File: tb/periodic_irq_flags_tb_top.sv
module periodic_irq_flags_tb_top;
    localparam int VBL = 20;
    localparam int SEC = 70;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    periodic_irq_flags #(.VBL_CYCLES(VBL), .SEC_CYCLES(SEC)) dut_i (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // reference model built from the requirements
    int cyc = 0;
    logic [6:0] m_f = '0;
    logic [6:0] m_e = '0;
    always @(posedge clk) begin
        if (rst) begin
            cyc = 0; m_f = '0; m_e = '0;
        end else begin
            cyc = cyc + 1;
            if (sel && wr_en && addr[12:9] == 4'd13) m_f = m_f & ~wdata[6:0];
            if (sel && wr_en && addr[12:9] == 4'd14)
                m_e = wdata[7] ? (m_e | wdata[6:0]) : (m_e & ~wdata[6:0]);
            if (cyc % VBL == 0) m_f[1] = 1'b1;
            if (cyc % SEC == 0) m_f[0] = 1'b1;
        end
    end

    function automatic logic [7:0] exp_read(input logic [3:0] o);
        if (o == 4'd13) return {|(m_f & m_e), m_f};
        if (o == 4'd14) return {1'b1, m_e};
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] o, input logic [8:0] low, input logic [7:0] d);
        sel = 1'b1; wr_en = 1'b1; addr = {o, low}; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic do_read(input logic [3:0] o, input logic [8:0] low, output logic [7:0] v);
        sel = 1'b1; wr_en = 1'b0; addr = {o, low};
        #1 v = rdata;
        sel = 1'b0; addr = '0;
    endtask

    task automatic model_read(input string tag, input logic [3:0] o);
        logic [7:0] v;
        do_read(o, 9'h000, v);
        check(tag, v, exp_read(o));
        check({tag, " R7 irq"}, {7'b0, irq}, {7'b0, |(m_f & m_e)});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // {wait[7:0], is_write, offset[3:0], data[7:0]}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {8'd0,  1'b0, 4'd13, 8'h00},
        {8'd0,  1'b1, 4'd14, 8'h82},
        {8'd0,  1'b0, 4'd14, 8'h00},
        {8'd25, 1'b0, 4'd13, 8'h00},
        {8'd0,  1'b1, 4'd13, 8'h02},
        {8'd0,  1'b0, 4'd13, 8'h00},
        {8'd0,  1'b1, 4'd14, 8'h01},
        {8'd0,  1'b0, 4'd14, 8'h00},
        {8'd50, 1'b0, 4'd13, 8'h00},
        {8'd0,  1'b1, 4'd14, 8'h81},
        {8'd0,  1'b0, 4'd13, 8'h00},
        {8'd0,  1'b1, 4'd14, 8'h7F},
        {8'd0,  1'b0, 4'd14, 8'h00},
        {8'd30, 1'b0, 4'd13, 8'h00}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        @(negedge clk);
        do_reset();

        // R9: reset state
        do_read(4'd13, 9'h000, v); check("R9 flags after reset", v, 8'h00);
        do_read(4'd14, 9'h000, v); check("R9 R6 enables after reset", v, 8'h80);
        check("R9 irq after reset", {7'b0, irq}, 8'h00);

        // R1/R2: exact boundary placement, flags latched while disabled (R3)
        while (cyc < VBL - 1) @(negedge clk);
        do_read(4'd13, 9'h000, v); check("R1 one edge before boundary", v, 8'h00);
        @(negedge clk);
        do_read(4'd13, 9'h000, v); check("R1 on boundary", v, 8'h02);
        check("R3 disabled flag gives no irq", {7'b0, irq}, 8'h00);
        while (cyc < SEC - 1) @(negedge clk);
        do_read(4'd13, 9'h000, v); check("R2 one edge before second", v & 8'h01, 8'h00);
        @(negedge clk);
        do_read(4'd13, 9'h000, v); check("R2 on second boundary", v & 8'h01, 8'h01);

        // R4: bit 7 and zero bits do not clear; R8 aliasing and undecoded offsets
        do_write(4'd13, 9'h000, 8'h80);
        do_read(4'd13, 9'h000, v); check("R4 bit7 write ignored", v & 8'h03, 8'h03);
        do_write(4'd12, 9'h000, 8'h7F);
        do_read(4'd13, 9'h000, v); check("R8 undecoded write ignored", v & 8'h03, 8'h03);
        do_read(4'd12, 9'h000, v); check("R8 undecoded read zero", v, 8'h00);
        do_write(4'd13, 9'h1A5, 8'h01);
        do_read(4'd13, 9'h0FF, v); check("R8 R4 aliased clear of bit0", v & 8'h01, 8'h00);
        do_write(4'd14, 9'h111, 8'h81);
        do_read(4'd14, 9'h000, v); check("R6 R8 aliased enable set", v, 8'h81);
        do_write(4'd14, 9'h000, 8'h01);
        do_read(4'd14, 9'h000, v); check("R6 enable clear", v, 8'h80);

        // R5: clear on the same edge as a tick
        while ((cyc + 1) % VBL != 0) @(negedge clk);
        do_write(4'd13, 9'h000, 8'h02);
        do_read(4'd13, 9'h000, v); check("R5 tick beats clear", v & 8'h02, 8'h02);

        // table-driven sequence after a fresh reset (R1 R2 R3 R6 R7)
        do_reset();
        for (int i = 0; i < NV; i++) begin
            repeat (int'(VEC[i][20:13])) @(negedge clk);
            if (VEC[i][12]) do_write(VEC[i][11:8], 9'h000, VEC[i][7:0]);
            else model_read($sformatf("R7 table step %0d", i), VEC[i][11:8]);
        end

        // R7: irq follows enable with the flag present
        do_write(4'd14, 9'h000, 8'h82);
        do_read(4'd13, 9'h000, v);
        check("R7 summary bit with irq", {7'b0, v[7]}, {7'b0, irq});
        check("R7 irq when enabled flag set", {7'b0, irq}, {7'b0, m_f[1]});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule